// File: doc/BRIEF.md
# Streaming 5x5 Convolution Sum-of-Products Engine

This block takes a raster stream of signed 16-bit image pixels, one per accepted transfer. It builds a 5x5 sliding window from four row-length line buffers and a short column shift register. Each pixel is therefore taken from the stream exactly once per pass. For every window position that lies fully inside the image, the 25 window pixels are multiplied by 25 privately held signed 16-bit weights. The products are reduced by a balanced adder tree, and the sum is normalised by an arithmetic right shift. The incoming partial-sum pixel is then added and the result is clamped to signed 16 bits. That result is emitted as an outgoing partial-sum pixel.

Loops over input and output feature maps happen outside this block, and so does address generation. A controller loads a filter once through the weight port, then streams one input feature map per frame while feeding the matching partial sums. The returned partial sums can be fed back on a later pass. A two-state controller tracks the frame. `ST_PRIME` covers the first four rows, where no window is complete. `ST_STREAM` covers the remaining rows. The transition *prime_done* moves from `ST_PRIME` to `ST_STREAM` when the last pixel of the fourth row is accepted. The transition *frame_done* moves from `ST_STREAM` back to `ST_PRIME` when the last pixel of the last row is accepted.

Top module: `stream_conv5x5`

## Requirements
- R1: After reset `y_out_valid` is 0, `x_ready` is 1 and `y_in_ready` is 0, and the controller is in `ST_PRIME`.
- R2: For the window whose bottom-right pixel is at row R, column C (both counted from 0 in raster order), the result uses tap i (0..24). Tap i is weight slot i times pixel (R-4+i/5, C-4+i%5), so slot 0 is the top-left and slot 24 is the bottom-right. All products are signed.
- R3: A cycle with `wt_we`=1 stores `wt_data` into weight slot `wt_idx`. Weights persist unchanged across frames until rewritten.
- R4: The tap sum is shifted right arithmetically by `shift_amt` (0..31), which rounds toward minus infinity, before `y_in_data` is added.
- R5: The final sum is clamped to the range -32768..32767.
- R6: Positions with R<4 or C<4 produce no output and consume no `y_in`. A frame of ROW_W x IMG_H pixels yields exactly (ROW_W-4)*(IMG_H-4) outputs, in raster order.
- R7: One `y_in` item is consumed in the same cycle as the pixel that completes each window, and the item consumed for the k-th window is added to the k-th result.
- R8: While `y_out_valid`=1 and `y_out_ready`=0, `y_out_data` holds its value, and no further window-completing pixel or `y_in` item is accepted.
- R9: A result becomes valid on `y_out_valid` in the cycle after its completing pixel is accepted.
- R10: After the last pixel of row IMG_H-1 the block returns to `ST_PRIME`. The next frame's outputs use only that frame's pixels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| shift_amt | input | SHIFT_W | Right-shift amount for normalisation |
| wt_we | input | 1 | Weight write strobe |
| wt_idx | input | 5 | Weight slot index (0..24) |
| wt_data | input | 16 | Signed weight value |
| x_valid | input | 1 | Input pixel valid |
| x_data | input | 16 | Signed input pixel |
| x_ready | output | 1 | Input pixel accepted when high with x_valid |
| y_in_valid | input | 1 | Incoming partial sum valid |
| y_in_data | input | 16 | Signed incoming partial sum |
| y_in_ready | output | 1 | Partial sum consumed when high with y_in_valid |
| y_out_valid | output | 1 | Output partial sum valid |
| y_out_data | output | 16 | Signed saturated output partial sum |
| y_out_ready | input | 1 | Downstream accepts the output |

## Verification
Two events can fall in the same cycle. One is the output register being drained by `y_out_ready`. The other is the register being reloaded by a newly completed window, along with the consumption of the matching `y_in` item. The bench provokes this by holding `y_out_ready` high while streaming at full rate, and separately by toggling `y_out_ready` at random while the pixel and partial-sum streams have random gaps. It judges the outcome by comparing every output, in order, with a value computed independently from the pixels, the weights and the partial sums. It also checks that a stalled output keeps its value, and that the number of consumed partial sums equals the number of outputs.

// File: rtl/conv5_pkg.sv
package conv5_pkg;
    localparam int PIX_W   = 16;
    localparam int KDIM    = 5;
    localparam int NTAP    = KDIM * KDIM;
    localparam int TAP_IW  = $clog2(NTAP);
    localparam int PROD_W  = 2 * PIX_W;
    localparam int TREE_LV = $clog2(NTAP);
    localparam int NLEAF   = 1 << TREE_LV;
    localparam int SUM_W   = PROD_W + TREE_LV;

    typedef logic signed [PIX_W-1:0] pix_t;

    typedef enum logic [0:0] {
        ST_PRIME  = 1'b0,
        ST_STREAM = 1'b1
    } phase_e;

    // Clamp a wide signed value to the 16-bit signed range
    function automatic pix_t clamp16(input logic signed [SUM_W:0] v);
        logic [SUM_W-PIX_W+1:0] top;
        top = v[SUM_W:PIX_W-1];
        if (top == '0 || top == '1)
            return v[PIX_W-1:0];
        else if (v[SUM_W])
            return 16'sh8000;
        else
            return 16'sh7fff;
    endfunction
endpackage

// File: rtl/conv5_ctrl.sv
module conv5_ctrl
    import conv5_pkg::*;
#(
    parameter int ROW_W = 9,
    parameter int IMG_H = 7,
    localparam int COL_W = $clog2(ROW_W),
    localparam int ROW_CW = $clog2(IMG_H)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             x_valid,
    input  logic             y_in_valid,
    input  logic             out_free,
    output logic             x_ready,
    output logic             y_in_ready,
    output logic             x_fire,
    output logic             win_hit,
    output logic [COL_W-1:0] col
);
    phase_e              st_q, st_d;
    logic [COL_W-1:0]    col_q;
    logic [ROW_CW-1:0]   row_q;
    logic                need_y;
    logic                last_col;

    assign last_col = (col_q == COL_W'(ROW_W - 1));
    assign col      = col_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_PRIME;
        else        st_q <= st_d;
    end

    // next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_PRIME: begin
                if (x_fire && last_col && row_q == ROW_CW'(KDIM - 2))
                    st_d = ST_STREAM;
            end
            ST_STREAM: begin
                if (x_fire && last_col && row_q == ROW_CW'(IMG_H - 1))
                    st_d = ST_PRIME;
            end
        endcase
    end

    // outputs
    always_comb begin
        need_y = 1'b0;
        unique case (st_q)
            ST_PRIME:  need_y = 1'b0;
            ST_STREAM: need_y = (col_q >= COL_W'(KDIM - 1));
        endcase
        x_ready    = !need_y || (y_in_valid && out_free);
        y_in_ready = need_y && x_valid && out_free;
        x_fire     = x_valid && x_ready;
        win_hit    = x_fire && need_y;
    end

    // raster position counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (x_fire) begin
            if (last_col) begin
                col_q <= '0;
                row_q <= (row_q == ROW_CW'(IMG_H - 1)) ? '0 : row_q + 1'b1;
            end else begin
                col_q <= col_q + 1'b1;
            end
        end
    end

    // R6
    prime_no_yin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRIME) |-> !y_in_ready);

    // R7
    yin_lockstep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_in_valid && y_in_ready) |-> (x_valid && x_ready));

    // R10
    stream_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_STREAM) |-> (row_q >= ROW_CW'(KDIM - 1)));

    // R10
    prime_rows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_PRIME) |-> (row_q < ROW_CW'(KDIM - 1) && col_q < COL_W'(ROW_W)));
endmodule

// File: rtl/conv5_linebuf.sv
module conv5_linebuf
    import conv5_pkg::*;
#(
    parameter int ROW_W = 9,
    localparam int COL_W = $clog2(ROW_W),
    localparam int NLB = KDIM - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    x_fire,
    input  logic [COL_W-1:0]        col,
    input  pix_t                    x_data,
    output logic [NTAP*PIX_W-1:0]   taps
);
    // lb[j][c]: pixel of row (current-1-j) at column c
    pix_t lb  [NLB][ROW_W];
    // csr[c][j]: older column c (NLB-1 is the most recent), j rows back
    pix_t csr [NLB][KDIM];
    pix_t nc  [KDIM];

    always_comb begin
        nc[0] = x_data;
        for (int j = 1; j < KDIM; j++)
            nc[j] = lb[j-1][col];
    end

    always_ff @(posedge clk) begin
        if (x_fire) begin
            for (int j = 0; j < NLB; j++)
                lb[j][col] <= nc[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NLB; c++)
                for (int j = 0; j < KDIM; j++)
                    csr[c][j] <= '0;
        end else if (x_fire) begin
            for (int c = 0; c < NLB - 1; c++)
                csr[c] <= csr[c+1];
            csr[NLB-1] <= nc;
        end
    end

    // tap index r*KDIM+c, r=0 is the oldest row, c=0 the oldest column
    for (genvar r = 0; r < KDIM; r++) begin : g_row
        for (genvar c = 0; c < KDIM; c++) begin : g_col
            if (c == KDIM - 1) begin : g_live
                assign taps[(r*KDIM+c)*PIX_W +: PIX_W] = nc[KDIM-1-r];
            end else begin : g_held
                assign taps[(r*KDIM+c)*PIX_W +: PIX_W] = csr[c][KDIM-1-r];
            end
        end
    end
endmodule

// File: rtl/conv5_sop.sv
module conv5_sop
    import conv5_pkg::*;
#(
    parameter int SHIFT_W = 5
) (
    input  logic [NTAP*PIX_W-1:0]    taps,
    input  logic [NTAP*PIX_W-1:0]    wts,
    input  logic [SHIFT_W-1:0]       shift_amt,
    output logic signed [SUM_W-1:0]  norm
);
    logic signed [SUM_W-1:0] lvl [TREE_LV+1][NLEAF];

    for (genvar i = 0; i < NLEAF; i++) begin : g_leaf
        if (i < NTAP) begin : g_mul
            logic signed [PROD_W-1:0] prod;
            assign prod = $signed(taps[i*PIX_W +: PIX_W]) * $signed(wts[i*PIX_W +: PIX_W]);
            assign lvl[0][i] = SUM_W'(prod);
        end else begin : g_pad
            assign lvl[0][i] = '0;
        end
    end

    for (genvar l = 0; l < TREE_LV; l++) begin : g_lvl
        for (genvar i = 0; i < NLEAF; i++) begin : g_node
            if (i < (NLEAF >> (l + 1))) begin : g_add
                assign lvl[l+1][i] = lvl[l][2*i] + lvl[l][2*i+1];
            end else begin : g_zero
                assign lvl[l+1][i] = '0;
            end
        end
    end

    assign norm = lvl[TREE_LV][0] >>> shift_amt;
endmodule

// File: rtl/stream_conv5x5.sv
module stream_conv5x5
    import conv5_pkg::*;
#(
    parameter int ROW_W   = 9,
    parameter int IMG_H   = 7,
    parameter int SHIFT_W = 5,
    localparam int COL_W  = $clog2(ROW_W)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [SHIFT_W-1:0] shift_amt,
    input  logic               wt_we,
    input  logic [TAP_IW-1:0]  wt_idx,
    input  logic [PIX_W-1:0]   wt_data,
    input  logic               x_valid,
    input  logic [PIX_W-1:0]   x_data,
    output logic               x_ready,
    input  logic               y_in_valid,
    input  logic [PIX_W-1:0]   y_in_data,
    output logic               y_in_ready,
    output logic               y_out_valid,
    output logic [PIX_W-1:0]   y_out_data,
    input  logic               y_out_ready
);
    logic                    out_free;
    logic                    x_fire;
    logic                    win_hit;
    logic [COL_W-1:0]        col;
    logic [NTAP*PIX_W-1:0]   taps;
    logic [NTAP*PIX_W-1:0]   wflat;
    logic signed [SUM_W-1:0] norm;
    logic signed [SUM_W:0]   acc;

    assign out_free = !y_out_valid || y_out_ready;

    conv5_ctrl #(.ROW_W(ROW_W), .IMG_H(IMG_H)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .x_valid(x_valid), .y_in_valid(y_in_valid),
        .out_free(out_free), .x_ready(x_ready), .y_in_ready(y_in_ready),
        .x_fire(x_fire), .win_hit(win_hit), .col(col)
    );

    conv5_linebuf #(.ROW_W(ROW_W)) u_lb (
        .clk(clk), .rst_n(rst_n), .x_fire(x_fire), .col(col),
        .x_data(pix_t'(x_data)), .taps(taps)
    );

    // weight slots
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wflat <= '0;
        end else if (wt_we) begin
            for (int i = 0; i < NTAP; i++)
                if (wt_idx == TAP_IW'(i))
                    wflat[i*PIX_W +: PIX_W] <= wt_data;
        end
    end

    conv5_sop #(.SHIFT_W(SHIFT_W)) u_sop (
        .taps(taps), .wts(wflat), .shift_amt(shift_amt), .norm(norm)
    );

    assign acc = (SUM_W+1)'(norm) + (SUM_W+1)'($signed(y_in_data));

    // output register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            y_out_valid <= 1'b0;
            y_out_data  <= '0;
        end else if (win_hit) begin
            y_out_valid <= 1'b1;
            y_out_data  <= clamp16(acc);
        end else if (y_out_ready) begin
            y_out_valid <= 1'b0;
        end
    end

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_out_valid && !y_out_ready) |=> (y_out_valid && $stable(y_out_data)));

    // R8
    stall_yin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (y_out_valid && !y_out_ready) |-> !y_in_ready);

    // R9
    out_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(y_out_valid) |-> $past(x_valid && x_ready && y_in_valid && y_in_ready));
endmodule

// File: tb/stream_conv5x5_test.sv
module stream_conv5x5_test;
    localparam int PERIOD = 10;
    localparam int HALF   = PERIOD / 2;
    localparam int W      = 9;
    localparam int H      = 7;
    localparam int NPIX   = W * H;
    localparam int NOUT   = (W - 4) * (H - 4);

    logic        clk = 0;
    logic        rst_n = 0;
    logic [4:0]  shift_amt = '0;
    logic        wt_we = 0;
    logic [4:0]  wt_idx = '0;
    logic [15:0] wt_data = '0;
    logic        x_valid = 0;
    logic [15:0] x_data = '0;
    logic        x_ready;
    logic        y_in_valid = 0;
    logic [15:0] y_in_data = '0;
    logic        y_in_ready;
    logic        y_out_valid;
    logic [15:0] y_out_data;
    logic        y_out_ready = 0;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    logic signed [15:0] pix [NPIX];
    logic signed [15:0] yv  [NOUT];
    logic signed [15:0] wts [25];
    int                 fire_cyc [NOUT];

    stream_conv5x5 #(.ROW_W(W), .IMG_H(H), .SHIFT_W(5)) uut (
        .clk(clk), .rst_n(rst_n), .shift_amt(shift_amt), .wt_we(wt_we),
        .wt_idx(wt_idx), .wt_data(wt_data), .x_valid(x_valid), .x_data(x_data),
        .x_ready(x_ready), .y_in_valid(y_in_valid), .y_in_data(y_in_data),
        .y_in_ready(y_in_ready), .y_out_valid(y_out_valid), .y_out_data(y_out_data),
        .y_out_ready(y_out_ready)
    );

    initial forever #HALF clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int model(int k, int sh);
        longint s = 0;
        int r = 4 + k / (W - 4);
        int c = 4 + k % (W - 4);
        for (int i = 0; i < 25; i++)
            s += longint'(wts[i]) * longint'(pix[(r - 4 + i / 5) * W + (c - 4 + i % 5)]);
        s = s >>> sh;
        s += longint'(yv[k]);
        if (s > 32767) s = 32767;
        if (s < -32768) s = -32768;
        return int'(s);
    endfunction

    function automatic bit completes(int p);
        return (p / W >= 4) && (p % W >= 4);
    endfunction

    task automatic load_weights();
        for (int i = 0; i < 25; i++) begin
            @(negedge clk);
            wt_we = 1; wt_idx = 5'(i); wt_data = wts[i];
        end
        @(negedge clk);
        wt_we = 0;
    endtask

    task automatic run_frame(input string tag, input int sh, input int gap, input int bp);
        int xi = 0, yi = 0, ko = 0, kx = 0, guard = 0;
        bit xf = 0, yf = 0, hold = 0;
        logic [15:0] held = '0;
        @(negedge clk);
        shift_amt = 5'(sh);
        while (ko < NOUT && guard < 4000) begin
            @(negedge clk);
            if (xf) xi++;
            if (yf) yi++;
            if (!x_valid || xf) begin
                x_valid = (xi < NPIX) && (($urandom % 100) >= gap);
                x_data  = (xi < NPIX) ? pix[xi] : '0;
            end
            if (!y_in_valid || yf) begin
                y_in_valid = (yi < NOUT) && (($urandom % 100) >= gap);
                y_in_data  = (yi < NOUT) ? yv[yi] : '0;
            end
            y_out_ready = ($urandom % 100) >= bp;
            #(HALF - 1);
            if (hold) begin
                // R8: stalled output keeps its value
                check(y_out_valid && y_out_data == held, "R8", {tag, " held output"},
                      int'($signed(y_out_data)), int'($signed(held)));
            end
            hold = y_out_valid && !y_out_ready;
            held = y_out_data;
            xf = x_valid && x_ready;
            yf = y_in_valid && y_in_ready;
            if (xf && completes(xi)) begin
                fire_cyc[kx] = cyc;
                kx++;
            end
            if (y_out_valid && y_out_ready) begin
                // R2 R4 R5 R7: value of k-th output
                check(int'($signed(y_out_data)) == model(ko, sh), "R2", {tag, " output value"},
                      int'($signed(y_out_data)), model(ko, sh));
                if (bp == 0 && ko < kx)
                    // R9: one-cycle latency
                    check(cyc == fire_cyc[ko] + 1, "R9", {tag, " latency"}, cyc, fire_cyc[ko] + 1);
                ko++;
            end
            cyc++;
            guard++;
        end
        if (xf) xi++;
        if (yf) yi++;
        @(negedge clk);
        x_valid = 0; y_in_valid = 0; y_out_ready = 1;
        check(ko == NOUT, "R6", {tag, " output count"}, ko, NOUT);
        check(yi == NOUT, "R7", {tag, " partial sums consumed"}, yi, NOUT);
        check(xi == NPIX, "R6", {tag, " pixels consumed"}, xi, NPIX);
        repeat (3) @(negedge clk);
        #(HALF - 1);
        // R6: no stray output beyond the frame
        check(!y_out_valid, "R6", {tag, " idle after frame"}, y_out_valid, 0);
        // R10: back in priming, so pixels accepted without partial sums
        check(x_ready && !y_in_ready, "R10", {tag, " frame restart"}, x_ready, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        #(HALF - 1);
        // R1: reset state
        check(!y_out_valid, "R1", "y_out_valid at reset", y_out_valid, 0);
        check(x_ready, "R1", "x_ready at reset", x_ready, 1);
        @(negedge clk);
        rst_n = 1;
        #(HALF - 1);
        check(!y_in_ready && !y_out_valid, "R1", "idle after reset", y_in_ready, 0);

        // R2 R3 R9: random weights, full rate
        for (int i = 0; i < 25; i++) wts[i] = 16'($urandom);
        load_weights();
        for (int p = 0; p < NPIX; p++) pix[p] = 16'($urandom);
        for (int k = 0; k < NOUT; k++) yv[k] = 16'($urandom);
        run_frame("full-rate", 14, 0, 0);

        // R3 R8 R10: same weights kept, gaps and backpressure
        for (int p = 0; p < NPIX; p++) pix[p] = 16'($urandom);
        for (int k = 0; k < NOUT; k++) yv[k] = 16'($urandom);
        run_frame("stalled", 20, 30, 40);

        // R4: small values, negative sums rounded down
        for (int i = 0; i < 25; i++) wts[i] = 16'(int'($urandom % 9) - 4);
        load_weights();
        for (int p = 0; p < NPIX; p++) pix[p] = 16'(int'($urandom % 201) - 100);
        for (int k = 0; k < NOUT; k++) yv[k] = 16'(int'($urandom % 21) - 10);
        run_frame("shift3", 3, 20, 20);
        run_frame("shift31", 31, 10, 10);

        // R5: positive and negative saturation
        for (int i = 0; i < 25; i++) wts[i] = 16'sh7fff;
        load_weights();
        for (int p = 0; p < NPIX; p++) pix[p] = 16'sh7fff;
        for (int k = 0; k < NOUT; k++) yv[k] = 16'($urandom);
        run_frame("sat-pos", 0, 0, 30);
        for (int p = 0; p < NPIX; p++) pix[p] = 16'sh8000;
        run_frame("sat-neg", 0, 25, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule